// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. It runs on a slow timer clock, nominally 32768 Hz. A prescaler divides that clock, and a 16-bit down-counter counts the divided ticks. When the counter runs out while the watchdog is enabled, the block emits a one-cycle reset request and sets a sticky expired flag. Timeouts from about one second to several hundred seconds can be set through the divisor and reload fields.

Every write must carry the key value 0x1234 in bits 31:16 of the write data. The block drops any write without that key, so a stray store cannot reprogram or service the watchdog. Firmware stages a divisor and a reload count and sets the enable bit. It services the watchdog by flipping 2-bit code groups in the refresh register between 1 and 2. Flipping the counter group restarts the countdown. Flipping the configuration group moves the staged divisor and reload values into the active copies that the timer uses. Read data is combinational while the read strobe is high.

Top module: `keyed_watchdog`

## Requirements
- R1: A write whose bits 31:16 differ from 0x1234 changes no register. Only bits 15:0 of a keyed write carry content.
- R2: Reset values:
  - The watchdog is disabled and the expired flag is clear.
  - Offset 0x18 reads 0x15, so every group holds code 1.
  - Offset 0x04 reads 0x0F00, which is a divisor of 16.
  - Offset 0x08 reads 0xFFFF.
  - Offset 0x1C reads 0.
- R3: Offset 0x04 holds the divisor minus one in bits 15:8, and its other bits read 0. Offset 0x08 holds the 16-bit reload count. At offset 0x1C, bit 0 is the read/write enable and bit 1 is the read-only expired flag. All staged values read back as written.
- R4: Reads of any offset other than 0x04, 0x08, 0x18 and 0x1C return 0. Keyed writes to such offsets change nothing.
- R5: Offset 0x18 holds three 2-bit groups and reads back the last six bits written:
  - bits 5:4 are the configuration group;
  - bits 3:2 are the counter group;
  - bits 1:0 are the interrupt-value group.

  A group is serviced only when a write changes it from 1 to 2 or from 2 to 1. Rewriting the same code, or writing code 0 or 3, services nothing.
- R6: A counter-group service reloads the counter and clears the prescaler. With divisor D and active reload N ≥ 1, the reset request goes high exactly N·D cycles after the edge that captured the service, and it lasts one cycle.
- R7: A configuration-group service copies the staged divisor and reload values into the active copies. Staged writes alone do not change the timing. When both groups are serviced in one write, the counter loads the new reload value.
- R8: The expired flag is set together with the reset request, stays set, and is cleared by the next counter-group service.
- R9: While the enable bit is 0, the counter and prescaler hold and no reset request occurs. Counting resumes from where it stopped.
- R10: After an expiry, the counter reloads from the active reload value, so the requests repeat every N·D cycles.
- R11: An active reload value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wrData | input | 32 | Write data, key in bits 31:16 |
| rdData | output | 32 | Read data, 0 when rdEn is low |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
- **Read data:** rdData is valid in the same cycle as rdEn, so the bench samples it one nanosecond after driving the strobe.
- **Register writes:** a write is captured at the rising edge while wrEn is high, and its effect reads back from the next cycle on.
- **Reset request:** the request becomes visible in the cycle that follows edge r + N·D, where r is the capturing edge of the service write. The bench keeps a free-running edge counter, records its value at each capturing edge and at each request, and compares the difference with the expected count.
- **Pauses:** the edges counted between the service and the disable write are subtracted from the remaining time.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] WR_KEY = 16'h1234;
  localparam int OFF_CFG     = 'h04;
  localparam int OFF_LOAD    = 'h08;
  localparam int OFF_REFRESH = 'h18;
  localparam int OFF_START   = 'h1C;
  localparam int DIV_W       = 8;
  localparam int CNT_W       = 16;
  localparam int GRP_W       = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrCfg;
    logic             wrLoad;
    logic             wrStart;
    logic [15:0]      wrVal;
    logic             cfgRefresh;
    logic             cntRefresh;
  } kwdStrobe_t;

  // state the datapath exposes for reads
  typedef struct packed {
    logic [DIV_W-1:0] divM1Staged;
    logic [CNT_W-1:0] loadStaged;
    logic             enable;
    logic             expired;
  } kwdStatus_t;
endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  kwdStatus_t        status,
  output kwdStrobe_t        strobe,
  output logic [31:0]       rdData
);
  localparam int SVC_GROUPS = 2;           // counter group, config group
  localparam int REF_W = 3 * GRP_W;

  logic             keyOk;
  logic             wrOk;
  logic             hitCfg, hitLoad, hitRefresh, hitStart;
  logic [REF_W-1:0] refreshReg;
  logic [SVC_GROUPS-1:0] toggled;

  assign keyOk      = (wrData[31:16] == WR_KEY);
  assign wrOk       = wrEn && keyOk;
  assign hitCfg     = (addr == ADDR_W'(OFF_CFG));
  assign hitLoad    = (addr == ADDR_W'(OFF_LOAD));
  assign hitRefresh = (addr == ADDR_W'(OFF_REFRESH));
  assign hitStart   = (addr == ADDR_W'(OFF_START));

  // group g covers bits of the counter (g=0) and configuration (g=1) codes
  for (genvar g = 0; g < SVC_GROUPS; g++) begin : gGroup
    localparam int LO = GRP_W * (g + 1);
    logic [GRP_W-1:0] oldCode, newCode;
    assign oldCode = refreshReg[LO +: GRP_W];
    assign newCode = wrData[LO +: GRP_W];
    assign toggled[g] = ((oldCode == 2'd1) && (newCode == 2'd2)) ||
                        ((oldCode == 2'd2) && (newCode == 2'd1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshReg <= 6'b01_01_01;
    end else if (wrOk && hitRefresh) begin
      refreshReg <= wrData[REF_W-1:0];
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.wrVal      = wrData[15:0];
    strobe.wrCfg      = wrOk && hitCfg;
    strobe.wrLoad     = wrOk && hitLoad;
    strobe.wrStart    = wrOk && hitStart;
    strobe.cntRefresh = wrOk && hitRefresh && toggled[0];
    strobe.cfgRefresh = wrOk && hitRefresh && toggled[1];
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (hitCfg)          rdData = {16'h0, status.divM1Staged, 8'h00};
      else if (hitLoad)    rdData = {16'h0, status.loadStaged};
      else if (hitRefresh) rdData = {26'h0, refreshReg};
      else if (hitStart)   rdData = {30'h0, status.expired, status.enable};
    end
  end

  AST_BADKEY_NO_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !keyOk) |=> $stable(refreshReg)); // R1

endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int RST_DIV  = 16,
  parameter int RST_LOAD = 'hFFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  kwdStrobe_t strobe,
  output kwdStatus_t status,
  output logic       resetReq
);
  localparam logic [DIV_W-1:0] RST_DIVM1 = DIV_W'(RST_DIV - 1);
  localparam logic [CNT_W-1:0] RST_CNT   = CNT_W'(RST_LOAD);

  logic [DIV_W-1:0] divM1Staged, divM1Active, presc;
  logic [CNT_W-1:0] loadStaged, loadActive, cnt, reloadSrc;
  logic             enable, expired, tick;

  // staged registers and enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM1Staged <= RST_DIVM1;
      loadStaged  <= RST_CNT;
      enable      <= 1'b0;
    end else begin
      if (strobe.wrCfg)   divM1Staged <= strobe.wrVal[15:8];
      if (strobe.wrLoad)  loadStaged  <= strobe.wrVal;
      if (strobe.wrStart) enable      <= strobe.wrVal[0];
    end
  end

  // active copies
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM1Active <= RST_DIVM1;
      loadActive  <= RST_CNT;
    end else if (strobe.cfgRefresh) begin
      divM1Active <= divM1Staged;
      loadActive  <= loadStaged;
    end
  end

  assign reloadSrc = strobe.cfgRefresh ? loadStaged : loadActive;
  assign tick      = enable && (presc >= divM1Active);

  // prescaler, counter, expiry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc    <= '0;
      cnt      <= RST_CNT;
      expired  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (strobe.cntRefresh) begin
        cnt     <= reloadSrc;
        presc   <= '0;
        expired <= 1'b0;
      end else if (enable) begin
        if (tick) begin
          presc <= '0;
          if (cnt <= CNT_W'(1)) begin
            resetReq <= 1'b1;
            expired  <= 1'b1;
            cnt      <= loadActive;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end else begin
          presc <= presc + DIV_W'(1);
        end
      end
    end
  end

  always_comb begin
    status.divM1Staged = divM1Staged;
    status.loadStaged  = loadStaged;
    status.enable      = enable;
    status.expired     = expired;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && divM1Active != '0) |=> !resetReq); // R6
  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !resetReq); // R9
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strobe.cntRefresh) |=> $stable(cnt)); // R9
  AST_EXPIRED_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> expired); // R8

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RST_DIV  = 16,
  parameter int RST_LOAD = 'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              resetReq
);
  kwdStrobe_t strobe;
  kwdStatus_t status;

  kwd_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .status(status), .strobe(strobe), .rdData(rdData)
  );

  kwd_datapath #(.RST_DIV(RST_DIV), .RST_LOAD(RST_LOAD)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .resetReq(resetReq)
  );
endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        resetReq;

  int errors = 0, checks = 0;
  int cyc = 0, lastWrCyc = 0, pulseCyc = 0, pulseCnt = 0;
  bit done = 0;

  // bench model of readable state
  logic [7:0]  mDiv = 8'h0F;
  logic [15:0] mLoad = 16'hFFFF;
  logic [5:0]  mRef = 6'h15;
  logic        mEn = 1'b0;

  keyed_watchdog u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .resetReq(resetReq));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (resetReq) begin pulseCyc = cyc; pulseCnt++; end

  function automatic int expT(int d, int n);
    return (n == 0 ? 1 : n) * d;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h04: return {16'h0, mDiv, 8'h00};
      8'h08: return {16'h0, mLoad};
      8'h18: return {26'h0, mRef};
      8'h1C: return {31'h0, mEn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, bit goodKey);
    @(negedge clk);
    wrEn = 1'b1; addr = a;
    wrData = {goodKey ? 16'h1234 : 16'h4321, d};
    @(negedge clk);
    wrEn = 1'b0;
    lastWrCyc = cyc;
    if (goodKey) begin
      case (a)
        8'h04: mDiv = d[15:8];
        8'h08: mLoad = d;
        8'h18: mRef = d[5:0];
        8'h1C: mEn = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic svc(bit doCfg, bit doCnt);
    logic [5:0] nv;
    nv = mRef ^ {doCfg, doCfg, doCnt, doCnt, 2'b00};
    wr(8'h18, {10'h0, nv}, 1'b1);
  endtask

  task automatic waitPulse(int limit);
    int start;
    start = pulseCnt;
    for (int i = 0; i < limit && pulseCnt == start; i++) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r, p1, d, x, base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset values
    rd(8'h04, v); check("R2 cfg", v, 32'h0F00);
    rd(8'h08, v); check("R2 load", v, 32'hFFFF);
    rd(8'h18, v); check("R2 refresh", v, 32'h15);
    rd(8'h1C, v); check("R2 start", v, 32'h0);
    check("R2 no request", {31'h0, resetReq}, 32'h0);

    // R1 wrong key ignored
    wr(8'h08, 16'h1111, 1'b0); rd(8'h08, v); check("R1 load", v, 32'hFFFF);
    wr(8'h18, 16'h002A, 1'b0); rd(8'h18, v); check("R1 refresh", v, 32'h15);
    wr(8'h1C, 16'h0001, 1'b0); rd(8'h1C, v); check("R1 start", v, 32'h0);

    // R3 R4 R5 random register traffic (enable kept clear)
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [15:0] dv;
      bit gk;
      case ($urandom % 5)
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h18; 3: a = 8'h1C;
        default: a = 8'($urandom);
      endcase
      dv = 16'($urandom);
      if (a == 8'h1C) dv[0] = 1'b0;
      gk = ($urandom % 4) != 0;
      wr(a, dv, gk);
      rd(a, v); check("R3 R4 R5 readback", v, expRead(a));
    end

    // setup: D=4, N=5
    wr(8'h18, 16'h0015, 1'b1);
    wr(8'h04, 16'h0300, 1'b1);
    wr(8'h08, 16'd5, 1'b1);
    svc(1, 1);
    wr(8'h1C, 16'h0001, 1'b1);
    svc(0, 1); r = lastWrCyc;
    waitPulse(200);
    check("R6 timeout N*D", pulseCyc - r, expT(4, 5));
    @(negedge clk); check("R6 one-cycle pulse", {31'h0, resetReq}, 32'h0);
    rd(8'h1C, v); check("R8 expired set", v, 32'h3);
    p1 = pulseCyc;
    waitPulse(200);
    check("R10 repeat period", pulseCyc - p1, expT(4, 5));
    svc(0, 1); r = lastWrCyc;
    rd(8'h1C, v); check("R8 expired cleared", v, 32'h1);

    // R6 prescaler clear on mid-period service
    repeat (6) @(negedge clk);
    svc(0, 1); r = lastWrCyc;
    waitPulse(200);
    check("R6 mid-period reload", pulseCyc - r, expT(4, 5));

    // R7 staged reload without config service has no effect
    wr(8'h08, 16'd3, 1'b1);
    svc(0, 1); r = lastWrCyc;
    waitPulse(200);
    check("R7 staged only", pulseCyc - r, expT(4, 5));
    svc(1, 1); r = lastWrCyc;
    waitPulse(200);
    check("R7 config applied", pulseCyc - r, expT(4, 3));

    // R5 same code and code 3 do not service
    wr(8'h08, 16'd5, 1'b1);
    svc(1, 1); r = lastWrCyc;
    wr(8'h18, {10'h0, mRef}, 1'b1);
    wr(8'h18, {10'h0, mRef[5:4], 2'b11, mRef[1:0]}, 1'b1);
    wr(8'h18, {10'h0, mRef[5:4], 2'b01, mRef[1:0]}, 1'b1);
    waitPulse(200);
    check("R5 no false service", pulseCyc - r, expT(4, 5));

    // R9 disable holds counting
    svc(0, 1); r = lastWrCyc;
    repeat (2) @(negedge clk);
    wr(8'h1C, 16'h0000, 1'b1); d = lastWrCyc;
    base = pulseCnt;
    repeat (60) @(negedge clk);
    check("R9 no request while off", pulseCnt - base, 0);
    wr(8'h1C, 16'h0001, 1'b1); x = lastWrCyc;
    waitPulse(200);
    check("R9 resume remainder", pulseCyc - x, expT(4, 5) - (d - r));

    // R11 reload 0 acts as 1, divisor 2
    wr(8'h04, 16'h0100, 1'b1);
    wr(8'h08, 16'd0, 1'b1);
    svc(1, 1); r = lastWrCyc;
    waitPulse(50);
    check("R11 zero reload", pulseCyc - r, expT(2, 0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule